// File: doc/BRIEF.md
# MDIO Management Register Controller

This block lets a host reach the management registers of an Ethernet PHY through three 16-bit registers on a simple register bus. The host places the 16-bit value to be written in the write-data register. It then writes one command word that carries the PHY address, the PHY register number and the operation. The block turns that command into a serial management frame on MDC/MDIO. The frame is 32 ones of preamble, start `01`, opcode, two 5-bit address fields, a 2-bit turnaround and 16 data bits sent MSB first.

The operation bit the host set acts as the busy flag. It reads back as set while the frame is on the wire, and hardware clears it on the last MDC falling edge. The host polls it to find out when the frame has finished. For a read, the master releases MDIO from the turnaround onward and samples the line on each MDC rising edge. The 16 captured bits appear in the read-data register once the busy flag is clear. A line that no PHY drives is pulled high, so a read then returns 0xFFFF, which software takes to mean that no PHY is present. MDC is the system clock divided by `2*HALF_DIV` and stays low between frames.

Top module: `mdio_regctl`

## Requirements
- R1: Register select `bus_addr` 0 is the command word, 1 is the write-data word and 2 is the read-data word; any other select reads 0. In the command word, bits 12:8 hold the PHY address, bits 4:0 hold the register number, bit 13 requests a read and bit 14 requests a write. Bits 15 and 7:5 read back as 0.
- R2: Writing a command word with bit 13 or bit 14 set while idle starts a frame. A write frame is 32 ones, `01`, `01`, PHY address, register number, turnaround `10`, then the write-data word MSB first, with MDIO driven for all 64 bits.
- R3: The operation bit reads as set from the accepting clock edge and is cleared exactly `128*HALF_DIV` clock edges after it.
- R4: A read frame sends 32 ones, `01`, `10`, the PHY address and the register number. The master releases MDIO (`mdio_oe` low) for the last 18 bits and captures bits 48..63 from `mdio_i` on MDC rising edges, MSB first, into the read-data word.
- R5: With no device driving the line (input held at 1), a read returns 0xFFFF.
- R6: A command word written while busy is ignored. The command register keeps its earlier value with the busy bit still set, and no extra frame is sent.
- R7: A command with both bits 13 and 14 set is taken as a read, and only bit 13 reads back as set.
- R8: MDC has a period of `2*HALF_DIV` clocks during a frame and stays low when idle. `mdio_o` changes only on MDC falling edges.
- R9: A write frame leaves the read-data word unchanged. A command word with neither bit 13 nor bit 14 set stores the address fields but sends no frame.
- R10: After reset all three registers read 0, MDC is low and `mdio_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select (0 command, 1 write data, 2 read data) |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data for `bus_addr` (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven by the master |
| mdio_oe | output | 1 | High while the master drives MDIO |
| mdio_i | input | 1 | Management data seen on the line |

## Verification
A frame accepted at clock edge E0 has its MDC rising edges at E0+HALF_DIV*(2k+1) and its falling edges at E0+HALF_DIV*(2k+2), for k from 0 to 63. The busy bit and the read-data word change at E0+128*HALF_DIV. The bench polls the command register on every falling clock edge after the accepting edge, and it checks that the first poll showing the flag clear lands exactly on edge 128*HALF_DIV. A PHY model captures the line on each MDC rising edge and drives read data after each MDC falling edge. When the 64th bit arrives, it compares the captured bits and output enables against the expected frame that the host task pushed into the scoreboard queue. The read-data word is read only after the busy flag is seen clear.

// File: rtl/mdio_regctl_pkg.sv
package mdio_regctl_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_BIT     = 46;
  localparam int DATA_BIT   = 48;

  typedef enum logic [1:0] {
    ADR_CMD  = 2'd0,
    ADR_WDAT = 2'd1,
    ADR_RDAT = 2'd2
  } regsel_e;

  // Whole serial frame, first bit in the MSB.
  function automatic logic [63:0] frame_word(input logic rd, input logic [4:0] phy,
                                             input logic [4:0] ra, input logic [15:0] wd);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, ra,
            (rd ? 2'b11 : 2'b10), (rd ? 16'hFFFF : wd)};
  endfunction

  // Stored form of a host command: read wins over write, spare bits zero.
  function automatic logic [15:0] cmd_pack(input logic [15:0] raw);
    logic rd, wr;
    rd = raw[13];
    wr = raw[14] & ~raw[13];
    return {1'b0, wr, rd, raw[12:8], 3'b000, raw[4:0]};
  endfunction

  // The master lets go of the line from the turnaround of a read onward.
  function automatic logic line_released(input logic rd, input int unsigned idx);
    return rd && (idx >= TA_BIT);
  endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick     = run && (cnt == CW'(HALF_DIV - 1));
  assign rise_stb = tick && !mdc;
  assign fall_stb = tick && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R8
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n) !run |-> !mdc);
  // R8
  mdc_edge_alt_chk: assert property (@(posedge clk) disable iff (!rst_n) rise_stb |=> mdc);
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_regctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        start_rd,
  input  logic [4:0]  phy,
  input  logic [4:0]  ra,
  input  logic [15:0] wd,
  input  logic        rise_stb,
  input  logic        fall_stb,
  input  logic        mdio_i,
  output logic        active,
  output logic        frame_rd,
  output logic        done,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic [15:0] rd_word
);
  localparam int CNTW = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] sh;
  logic [CNTW-1:0]       cnt;
  logic                  sample;

  assign done    = active && fall_stb && (cnt == CNTW'(FRAME_BITS - 1));
  assign sample  = active && rise_stb && frame_rd && (int'(cnt) >= DATA_BIT);
  assign mdio_o  = sh[FRAME_BITS-1];
  assign mdio_oe = active && !line_released(frame_rd, int'(cnt));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      frame_rd <= 1'b0;
      sh       <= '0;
      cnt      <= '0;
      rd_word  <= '0;
    end else if (start && !active) begin
      active   <= 1'b1;
      frame_rd <= start_rd;
      sh       <= frame_word(start_rd, phy, ra, wd);
      cnt      <= '0;
    end else if (active) begin
      if (sample) rd_word <= {rd_word[14:0], mdio_i};
      if (fall_stb) begin
        sh  <= {sh[FRAME_BITS-2:0], 1'b0};
        cnt <= cnt + 1'b1;
        if (done) active <= 1'b0;
      end
    end
  end

  // R8
  mdio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active && !fall_stb |=> $stable(mdio_o));
  // R4
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample |-> !mdio_oe);
endmodule

// File: rtl/mdio_regctl.sv
module mdio_regctl
  import mdio_regctl_pkg::*;
#(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [15:0] cmd_q, wdat_q, rdat_q;
  logic        busy, cmd_wr, accept, start;
  logic        run, rise_stb, fall_stb, frame_done, frame_rd;
  logic [15:0] rd_word;
  logic [15:0] new_cmd;

  assign busy    = |cmd_q[14:13];
  assign cmd_wr  = bus_wr && (bus_addr == ADR_CMD);
  assign accept  = cmd_wr && !busy;
  assign new_cmd = cmd_pack(bus_wdata);
  assign start   = accept && |new_cmd[14:13];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
    end else begin
      if (accept)          cmd_q        <= new_cmd;
      else if (frame_done) cmd_q[14:13] <= 2'b00;
      if (bus_wr && bus_addr == ADR_WDAT) wdat_q <= bus_wdata;
      if (frame_done && frame_rd)         rdat_q <= rd_word;
    end
  end

  always_comb begin
    case (regsel_e'(bus_addr))
      ADR_CMD:  bus_rdata = cmd_q;
      ADR_WDAT: bus_rdata = wdat_q;
      ADR_RDAT: bus_rdata = rdat_q;
      default:  bus_rdata = 16'h0000;
    endcase
  end

  mdio_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run),
    .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  mdio_frame u_frame (
    .clk(clk), .rst_n(rst_n), .start(start), .start_rd(new_cmd[13]),
    .phy(new_cmd[12:8]), .ra(new_cmd[4:0]), .wd(wdat_q),
    .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_i(mdio_i),
    .active(run), .frame_rd(frame_rd), .done(frame_done),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_word(rd_word)
  );

  // R6
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && busy && !frame_done |=> $stable(cmd_q));
  // R3
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !busy);
  // R7
  one_op_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cmd_q[14:13]));
  // R9
  rdat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_done && frame_rd) |=> $stable(rdat_q));
  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy && run);
endmodule

// File: tb/mdio_regctl_bench.sv
`timescale 1ns/1ps
module mdio_regctl_bench;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  always #2.5 clk = ~clk;

  mdio_regctl #(.HALF_DIV(HALF)) u_mdio_regctl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int n_chk = 0, n_err = 0, n_frames = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Scoreboard of expected frames.
  typedef struct { bit rd; logic [4:0] phy; logic [4:0] ra; logic [15:0] d; } item_t;
  item_t exp_q[$];

  // PHY model.
  bit          phy_present = 1'b1;
  logic [15:0] phy_val = 16'h0;
  logic [63:0] cap = '0, oe_cap = '0;
  int          nb = 0;
  realtime     t_first = 0;

  always @(posedge mdc) begin
    cap[63-nb]    = mdio_o;
    oe_cap[63-nb] = mdio_oe;
    if (nb == 0) t_first = $realtime;
    if (nb == 1) chk(($realtime - t_first) == 2.0 * HALF * 5.0, "R8 mdc period",
                     64'($rtoi($realtime - t_first)), 64'(2 * HALF * 5));
    nb++;
    if (nb == 64) begin
      nb = 0;
      n_frames++;
      compare_frame();
    end
  end

  always @(negedge mdc) begin
    if (phy_present && cap[29] && !cap[28] && nb >= 48 && nb <= 63)
      mdio_i = phy_val[15 - (nb - 48)];
    else
      mdio_i = 1'b1;
  end

  task automatic compare_frame();
    item_t it;
    logic [63:0] e;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R6 unexpected frame", cap, 64'h0);
      return;
    end
    it = exp_q.pop_front();
    e = {32'hFFFF_FFFF, 2'b01, (it.rd ? 2'b10 : 2'b01), it.phy, it.ra, 2'b10, it.d};
    if (it.rd) begin
      chk(cap[63:18] == e[63:18], "R4 read frame header", {18'h0, cap[63:18]}, {18'h0, e[63:18]});
      chk(oe_cap == {46'h3FFF_FFFF_FFFF, 18'h0}, "R4 release window", oe_cap, {46'h3FFF_FFFF_FFFF, 18'h0});
    end else begin
      chk(cap == e, "R2 write frame bits", cap, e);
      chk(oe_cap == '1, "R2 write drive", oe_cap, '1);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // Polls on every falling clock edge after the accepting edge.
  task automatic wait_idle(output int cyc);
    cyc = 0;
    bus_addr = 2'd0;
    while (cyc < 5000) begin
      @(negedge clk);
      cyc++;
      #1;
      if (bus_rdata[14:13] == 2'b00) break;
    end
  endtask

  task automatic run_cmd(input bit rd, input logic [4:0] phy, input logic [4:0] ra,
                         input logic [15:0] wd, input string tag);
    item_t it;
    int cyc;
    it.rd = rd; it.phy = phy; it.ra = ra; it.d = wd;
    exp_q.push_back(it);
    bus_write(2'd1, wd);
    bus_write(2'd0, {1'b0, !rd, rd, phy, 3'b000, ra});
    wait_idle(cyc);
    chk(cyc == 128 * HALF, {"R3 busy duration ", tag}, 64'(cyc), 64'(128 * HALF));
    #1;
    chk(mdc == 1'b0, {"R8 mdc idle ", tag}, 64'(mdc), 64'h0);
  endtask

  initial begin
    logic [15:0] v;
    int cyc;
    int f0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R10 reset state
    bus_read(2'd0, v); chk(v == 16'h0, "R10 cmd reset", 64'(v), 64'h0);
    bus_read(2'd1, v); chk(v == 16'h0, "R10 wdata reset", 64'(v), 64'h0);
    bus_read(2'd2, v); chk(v == 16'h0, "R10 rdata reset", 64'(v), 64'h0);
    chk(!mdc && !mdio_oe, "R10 line idle", {mdc, mdio_oe}, 64'h0);

    // R1 write-data readback and unused select
    bus_write(2'd1, 16'h5A3C);
    bus_read(2'd1, v); chk(v == 16'h5A3C, "R1 wdata readback", 64'(v), 64'h5A3C);
    bus_read(2'd3, v); chk(v == 16'h0, "R1 unused select", 64'(v), 64'h0);

    // R2 write frame, R9 rdata untouched
    run_cmd(1'b0, 5'd5, 5'd3, 16'hA5C3, "wr1");
    bus_read(2'd0, v); chk(v == 16'h0503, "R1 cmd fields after write", 64'(v), 64'h0503);
    bus_read(2'd2, v); chk(v == 16'h0, "R9 rdata after write", 64'(v), 64'h0);

    // R4 reads with several patterns
    phy_present = 1'b1; phy_val = 16'h1234;
    run_cmd(1'b1, 5'd1, 5'd2, 16'h0, "rd1");
    bus_read(2'd2, v); chk(v == 16'h1234, "R4 read 1234", 64'(v), 64'h1234);
    phy_val = 16'h8001;
    run_cmd(1'b1, 5'd31, 5'd0, 16'h0, "rd2");
    bus_read(2'd2, v); chk(v == 16'h8001, "R4 read 8001", 64'(v), 64'h8001);
    phy_val = 16'h0000;
    run_cmd(1'b1, 5'd0, 5'd31, 16'h0, "rd3");
    bus_read(2'd2, v); chk(v == 16'h0000, "R4 read 0000", 64'(v), 64'h0);

    // R5 no PHY
    phy_present = 1'b0;
    run_cmd(1'b1, 5'd9, 5'd1, 16'h0, "rd4");
    bus_read(2'd2, v); chk(v == 16'hFFFF, "R5 no phy", 64'(v), 64'hFFFF);
    phy_present = 1'b1;

    // R6 command while busy
    begin
      item_t it;
      it.rd = 1'b0; it.phy = 5'd31; it.ra = 5'd31; it.d = 16'hFFFF;
      exp_q.push_back(it);
      bus_write(2'd1, 16'hFFFF);
      bus_write(2'd0, 16'h5F1F);
      repeat (10) @(negedge clk);
      bus_write(2'd0, 16'h2207);
      bus_read(2'd0, v); chk(v == 16'h5F1F, "R6 cmd kept while busy", 64'(v), 64'h5F1F);
      wait_idle(cyc);
      repeat (300) @(negedge clk);
      chk(exp_q.size() == 0, "R6 only first frame", 64'(exp_q.size()), 64'h0);
    end

    // R7 both op bits: read
    phy_val = 16'hBEEF;
    begin
      item_t it;
      it.rd = 1'b1; it.phy = 5'd3; it.ra = 5'd7; it.d = 16'h0;
      exp_q.push_back(it);
      bus_write(2'd0, 16'h6307);
      bus_read(2'd0, v); chk(v == 16'h2307, "R7 read wins", 64'(v), 64'h2307);
      wait_idle(cyc);
      bus_read(2'd2, v); chk(v == 16'hBEEF, "R7 read data", 64'(v), 64'hBEEF);
    end

    // R9 write keeps rdata
    run_cmd(1'b0, 5'd2, 5'd4, 16'h0F0F, "wr2");
    bus_read(2'd2, v); chk(v == 16'hBEEF, "R9 rdata kept", 64'(v), 64'hBEEF);

    // R9 no op bit: fields stored, no frame
    f0 = n_frames;
    bus_write(2'd0, 16'h8AE5);
    bus_read(2'd0, v); chk(v == 16'h0A05, "R9 fields no op", 64'(v), 64'h0A05);
    repeat (300) @(negedge clk);
    chk(n_frames == f0 && nb == 0 && !mdc, "R9 no frame", 64'(n_frames - f0), 64'h0);

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "watchdog", 64'h0, 64'h1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule